// File: doc/BRIEF.md
# Dual-Antenna Magnitude Selector

This block sits on the path between a paired odd-cell / even-cell video sample stream and the two accumulator banks that integrate it. Each input beat carries one adjacent pair: an odd-cell sample and an even-cell sample. A mode pin chooses how the pair is treated. In single-antenna operation, from either antenna, both samples are forwarded untouched. In dual-antenna operation the left antenna supplies the even stream and the right antenna supplies the odd stream. The block then compares the two samples of the pair and drives the larger one onto both output lanes. This way the strongest return survives in both banks.

The data interfaces use valid/ready. An input beat is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. An output beat is consumed when `out_valid` and `out_ready` are both high. The result sits in a single output register. `in_ready` is high whenever that register is empty or is being drained in the same cycle, so full throughput is kept without a skid buffer. While the consumer holds `out_ready` low, the held beat stays frozen and no input is taken. The mode pin is plain control. It is sampled only with an accepted beat, so a pair is never split across modes.

Top module: `dual_ant_mag_sel`

## Requirements
- R1: After reset, and until the first input beat is accepted, `out_valid` is 0.
- R2: With `dual_mode` = 0 at acceptance, the beat's output has `out_odd` equal to the accepted `in_odd` and `out_even` equal to the accepted `in_even`.
- R3: With `dual_mode` = 1 at acceptance, both `out_odd` and `out_even` equal the unsigned maximum of the accepted `in_odd` and `in_even`. When the two are equal, the even sample is the one selected.
- R4: An input beat accepted on a clock edge appears on the outputs, with `out_valid` = 1, immediately after that same edge (one register of latency).
- R5: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_odd` and `out_even` hold their values across the edge.
- R6: `dual_mode` is used only in a cycle in which a beat is accepted. Changing it while no beat is accepted leaves the held output unchanged.
- R7: `in_ready` equals 1 exactly when `out_valid` = 0 or `out_ready` = 1.
- R8: When the output beat is consumed and no new beat is accepted on the same edge, `out_valid` becomes 0 after that edge.
- R9: Samples are `DATA_W` bits wide, 3 by default, treated as unsigned magnitudes. The extremes 0 and 2^DATA_W-1 are handled without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dual_mode | input | 1 | 0 = single antenna (pass through), 1 = both antennas (pair maximum) |
| in_valid | input | 1 | Input pair is present |
| in_ready | output | 1 | Block can take an input pair this cycle |
| in_odd | input | DATA_W | Odd-cell sample (right antenna in dual mode) |
| in_even | input | DATA_W | Even-cell sample (left antenna in dual mode) |
| out_valid | output | 1 | Output pair is present |
| out_ready | input | 1 | Consumer takes the output pair this cycle |
| out_odd | output | DATA_W | Sample for the odd bank |
| out_even | output | DATA_W | Sample for the even bank |

## Verification
Each accepted pair is due on the outputs in the cycle after its accepting edge. `in_ready` is due in the same cycle as `out_ready`, through logic with no register. The bench drives inputs and reads outputs at the falling edge. At each falling edge it first compares the outputs against a reference register that it updated from the handshake seen in the previous half cycle. Only then does it apply new stimulus and check `in_ready` combinationally. Stalled cycles are tagged against the hold and mode-isolation requirements, so a result arriving a cycle early or late, or a result moving during a stall, is reported.

// File: rtl/dams_pkg.sv
package dams_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_DUAL   = 1'b1
  } ant_mode_e;
endpackage

// File: rtl/dams_pair_max.sv
module dams_pair_max #(
  parameter int DATA_W = 3
) (
  input  logic [DATA_W-1:0] smp_odd,
  input  logic [DATA_W-1:0] smp_even,
  output logic [DATA_W-1:0] big
);
  // Ties resolve to the even (left antenna) sample.
  always_comb begin
    if (smp_odd > smp_even) big = smp_odd;
    else                    big = smp_even;
  end

  // R3: selected value dominates both candidates and is one of them
  always_comb begin
    a_r3_max_bound: assert ((big >= smp_odd) && (big >= smp_even) &&
                            ((big == smp_odd) || (big == smp_even)));
  end
endmodule

// File: rtl/dams_out_stage.sv
module dams_out_stage #(
  parameter int DATA_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drain,
  input  logic [DATA_W-1:0] d_odd,
  input  logic [DATA_W-1:0] d_even,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_odd,
  output logic [DATA_W-1:0] q_even
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_odd   <= '0;
      q_even  <= '0;
    end else if (load) begin
      q_valid <= 1'b1;
      q_odd   <= d_odd;
      q_even  <= d_even;
    end else if (drain) begin
      q_valid <= 1'b0;
    end
  end

  // R4: a load always produces a valid beat
  a_r4_load_valid: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q_valid);

  // R8: a drain without a load empties the stage
  a_r8_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !load) |=> !q_valid);

  // R5: nothing moves without a load
  a_r5_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(q_odd) && $stable(q_even)));
endmodule

// File: rtl/dual_ant_mag_sel.sv
module dual_ant_mag_sel
  import dams_pkg::*;
#(
  parameter int DATA_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dual_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_odd,
  input  logic [DATA_W-1:0] in_even,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_odd,
  output logic [DATA_W-1:0] out_even
);
  localparam int LANES = 2;

  ant_mode_e         mode_now;
  logic              accept;
  logic              drain;
  logic [DATA_W-1:0] pair_big;
  logic [DATA_W-1:0] lane_in  [LANES];
  logic [DATA_W-1:0] lane_sel [LANES];

  assign mode_now = ant_mode_e'(dual_mode);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign drain    = out_valid && out_ready;

  assign lane_in[0] = in_even;
  assign lane_in[1] = in_odd;

  dams_pair_max #(.DATA_W(DATA_W)) u_max (
    .smp_odd  (in_odd),
    .smp_even (in_even),
    .big      (pair_big)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      unique case (mode_now)
        MODE_DUAL:   lane_sel[g] = pair_big;
        default:     lane_sel[g] = lane_in[g];
      endcase
    end
  end

  dams_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .drain   (drain),
    .d_odd   (lane_sel[1]),
    .d_even  (lane_sel[0]),
    .q_valid (out_valid),
    .q_odd   (out_odd),
    .q_even  (out_even)
  );

  // R5: a stalled beat keeps valid high
  a_r5_stall_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R3: a dual-mode beat carries the same value on both lanes
  a_r3_dual_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dual_mode) |=> (out_odd == out_even));

  // R2: a single-mode beat is passed as taken
  a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dual_mode) |=>
      ((out_odd == $past(in_odd)) && (out_even == $past(in_even))));

  // R7: no input is taken while a stalled beat is held
  a_r7_no_take_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/dual_ant_mag_sel_tb.sv
module dual_ant_mag_sel_tb;
  localparam int DW = 3;
  localparam int MAXV = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dual_mode = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_odd = '0;
  logic [DW-1:0] in_even = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_odd;
  logic [DW-1:0] out_even;

  int n_run = 0;
  int n_fail = 0;

  logic          m_valid = 1'b0;
  logic [DW-1:0] m_odd = '0;
  logic [DW-1:0] m_even = '0;
  logic          prev_stall = 1'b0;

  always #10 clk = ~clk;

  dual_ant_mag_sel #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_odd(in_odd), .in_even(in_even),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_odd(out_odd), .out_even(out_even)
  );

  function automatic logic [DW-1:0] ref_max(logic [DW-1:0] o, logic [DW-1:0] e);
    return (o > e) ? o : e;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Compare outputs against the reference register.
  task automatic check_out(input string tag);
    chk(out_valid == m_valid, {tag, " valid"}, out_valid, m_valid);
    if (m_valid) begin
      chk(out_odd == m_odd, {tag, " odd"}, out_odd, m_odd);
      chk(out_even == m_even, {tag, " even"}, out_even, m_even);
    end
  endtask

  // Drive one cycle at the falling edge, check ready, update the model.
  task automatic step(input bit v, input bit dm, input logic [DW-1:0] o,
                      input logic [DW-1:0] e, input bit rdy);
    bit acc;
    bit drn;
    in_valid = v; dual_mode = dm; in_odd = o; in_even = e; out_ready = rdy;
    #1;
    chk(in_ready == (!m_valid || rdy), "R7 in_ready", in_ready, (!m_valid || rdy));
    acc = v && (!m_valid || rdy);
    drn = m_valid && rdy;
    prev_stall = m_valid && !rdy;
    if (acc) begin
      m_valid = 1'b1;
      m_odd  = dm ? ref_max(o, e) : o;
      m_even = dm ? ref_max(o, e) : e;
    end else if (drn) begin
      m_valid = 1'b0;
    end
    @(negedge clk);
    if (acc) check_out(dm ? "R4 R3 dual" : "R4 R2 single");
    else if (prev_stall) check_out("R5 R6 stall hold");
    else check_out("R8 drain");
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 idle after reset", out_valid, 0);

    // Directed corners
    step(1, 1, 3'd6, 3'd2, 1);   // R3 odd larger
    step(1, 1, 3'd1, 3'd5, 1);   // R3 even larger
    step(1, 1, 3'd4, 3'd4, 1);   // R3 tie
    step(1, 1, 3'(MAXV), 3'd0, 1); // R9 extremes
    step(1, 1, 3'd0, 3'(MAXV), 1); // R9 extremes
    step(1, 0, 3'd7, 3'd0, 1);   // R2 pass
    step(1, 0, 3'd2, 3'd5, 0);   // R2 then stall begins
    step(1, 1, 3'd7, 3'd7, 0);   // R6 mode flip while stalled
    step(0, 0, 3'd0, 3'd0, 0);   // R5 still held
    step(0, 1, 3'd0, 3'd0, 1);   // R8 drain
    step(0, 0, 3'd0, 3'd0, 1);   // R8 idle

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, $urandom % 2,
           DW'($urandom), DW'($urandom), ($urandom % 3) != 0);
    end

    step(0, 0, 3'd0, 3'd0, 1);
    step(0, 0, 3'd0, 3'd0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule